// File: doc/BRIEF.md
# Shared-Pin General-Purpose Port

This block is an eight-pin general-purpose I/O port. Each pin has an output latch bit and a direction bit. Software reaches both through a small register bus with an address, a write strobe, write data and combinational read data. Every pin drives a modelled pad through an output-enable and an output-value signal. The incoming pad level passes through a two-flop synchronizer before any logic sees it.

Several peripherals can take pins over, and each one does so through its own enable input:

- A two-wire serial bus uses pin 0 for data and pin 1 for clock.
- A UART uses pin 2 to transmit and pin 3 to receive.
- Four timer channels use pins 4 to 7.

While a peripheral owns a pin, its drive wins over the port's direction bit and latch bit.

The four low pins are open-drain whatever drives them. They can pull the pad low or release it, but never push it high. The four high pins are push-pull. Reset clears the direction register, so every pin starts as an input. The output latch is not reset.

Each pin's driver has two states:

- PORT: direction and latch decide the drive.
- PERIPH: the peripheral's enable and value decide the drive.

A pin moves from PORT to PERIPH when its peripheral enable rises, and back when the enable falls. The move takes no clock; it is a mux selection.

Top module: `gpio_shared_port`

## Requirements
- R1: A write to offset 0x01 loads the eight latch bits. A read of 0x01 returns the latch bit for every pin whose direction bit is 1.
- R2: A write to offset 0x05 loads the direction register, where 1 means output. Reset clears it to 0x00, so after reset no pin is driven and 0x05 reads 0x00.
- R3: Reset leaves the latch unchanged. A value written before reset reads back unchanged once the pins are set as outputs.
- R4: For a pin whose direction bit is 0, a read of 0x01 returns the pad level delayed by the two-flop synchronizer. The level is visible two clock edges after the pad changes.
- R5: Pins 3..0 are open-drain. Their pad_out bit is always 0, and pad_oe is 1 only when the selected driver drives a 0.
- R6: Pins 7..4 are push-pull when the port owns them. pad_oe equals the direction bit, and pad_out equals the latch bit ANDed with the direction bit.
- R7: With twi_en high, pin 0 follows twi_sda_oe/twi_sda_o and pin 1 follows twi_scl_oe/twi_scl_o (open-drain), regardless of direction and latch.
- R8: With uart_tx_en high, pin 2 always drives uart_tx_o in open-drain form, so pad_oe[2] = ~uart_tx_o.
- R9: With uart_rx_en high, pin 3 is released (pad_oe[3] = 0) regardless of its direction bit.
- R10: With tmr_en[i] high, pin 4+i has pad_oe = tmr_oe[i] and pad_out = tmr_oe[i] & tmr_o[i]. Enables 0 and 1 are the first timer's two channels; enables 2 and 3 are the second timer's two channels.
- R11: The peripheral inputs twi_sda_i, twi_scl_i, uart_rx_i and tmr_i[3:0] carry the synchronized levels of pads 0, 1, 3 and 7..4, whatever the pin direction.
- R12: Writes to any offset other than 0x01 and 0x05 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Level seen at each pad |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| twi_en | input | 1 | Serial bus takes pins 0 and 1 |
| twi_sda_oe | input | 1 | Serial data drive enable |
| twi_sda_o | input | 1 | Serial data value |
| twi_scl_oe | input | 1 | Serial clock drive enable |
| twi_scl_o | input | 1 | Serial clock value |
| twi_sda_i | output | 1 | Synchronized pin 0 level |
| twi_scl_i | output | 1 | Synchronized pin 1 level |
| uart_tx_en | input | 1 | UART takes pin 2 |
| uart_tx_o | input | 1 | UART transmit value |
| uart_rx_en | input | 1 | UART takes pin 3 as input |
| uart_rx_i | output | 1 | Synchronized pin 3 level |
| tmr_en | input | 4 | Timer channel takes pin 4+i |
| tmr_oe | input | 4 | Timer channel drive enable |
| tmr_o | input | 4 | Timer channel value |
| tmr_i | output | 4 | Synchronized pin 7..4 levels |

## Verification
The bench sweeps all 256 direction values against several latch patterns, and compares pad drive and readback with a mask computation. These sweeps catch two faults:

- A design that drives the low nibble high would show a nonzero pad_out[3:0].
- A design with the wrong read mux would return pad bits for output pins.

A reset pulse in the middle of the run exposes a latch wrongly placed on reset, because the latch would read back as zero.

All serial-bus and timer drive combinations are swept with direction and latch set opposite to the peripheral. A missing override therefore leaks the port value. Pad changes are checked one cycle and two cycles after they occur, which exposes a synchronizer with one stage too many or too few.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W     = 8;
    localparam int OD_PINS    = 4;
    localparam int ADDR_W     = 4;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] OFS_LATCH = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 4'h5;

    typedef enum logic {
        OWN_PORT   = 1'b0,
        OWN_PERIPH = 1'b1
    } pin_owner_e;
endpackage

// File: rtl/port_regs.sv
module port_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pad_sync,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  bus_rdata
);
    logic hit_latch;
    logic hit_dir;

    assign hit_latch = (bus_addr == OFS_LATCH);
    assign hit_dir   = (bus_addr == OFS_DIR);

    // Output latch: deliberately outside the reset domain
    always_ff @(posedge clk) begin
        if (bus_we && hit_latch) begin
            latch_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (bus_we && hit_dir) begin
            dir_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_latch) begin
            bus_rdata = (latch_q & dir_q) | (pad_sync & ~dir_q);
        end else if (hit_dir) begin
            bus_rdata = dir_q;
        end
    end
endmodule

// File: rtl/pad_sync.sv
module pad_sync
    import gpio_port_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_sync
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage[i] <= '0;
            end
        end else begin
            stage[0] <= pad_in;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign pad_sync = stage[DEPTH-1];
endmodule

// File: rtl/pin_drive.sv
module pin_drive
    import gpio_port_pkg::*;
#(
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic port_dir,
    input  logic port_val,
    input  logic per_en,
    input  logic per_oe,
    input  logic per_val,
    output logic pad_oe,
    output logic pad_out
);
    pin_owner_e owner;
    logic       drv_en;
    logic       drv_val;

    assign owner = per_en ? OWN_PERIPH : OWN_PORT;

    always_comb begin
        unique case (owner)
            OWN_PORT: begin
                drv_en  = port_dir;
                drv_val = port_val;
            end
            OWN_PERIPH: begin
                drv_en  = per_oe;
                drv_val = per_val;
            end
            default: begin
                drv_en  = 1'b0;
                drv_val = 1'b0;
            end
        endcase
    end

    generate
        if (OPEN_DRAIN) begin : g_od
            assign pad_oe  = drv_en & ~drv_val;
            assign pad_out = 1'b0;
        end else begin : g_pp
            assign pad_oe  = drv_en;
            assign pad_out = drv_en & drv_val;
        end
    endgenerate
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    input  logic              twi_en,
    input  logic              twi_sda_oe,
    input  logic              twi_sda_o,
    input  logic              twi_scl_oe,
    input  logic              twi_scl_o,
    output logic              twi_sda_i,
    output logic              twi_scl_i,
    input  logic              uart_tx_en,
    input  logic              uart_tx_o,
    input  logic              uart_rx_en,
    output logic              uart_rx_i,
    input  logic [3:0]        tmr_en,
    input  logic [3:0]        tmr_oe,
    input  logic [3:0]        tmr_o,
    output logic [3:0]        tmr_i
);
    localparam int PIN_SDA = 0;
    localparam int PIN_SCL = 1;
    localparam int PIN_TX  = 2;
    localparam int PIN_RX  = 3;
    localparam int PIN_TMR = 4;

    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] sync_q;
    logic [PORT_W-1:0] per_en;
    logic [PORT_W-1:0] per_oe;
    logic [PORT_W-1:0] per_val;

    port_regs #(.W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pad_sync  (sync_q),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .bus_rdata (bus_rdata)
    );

    pad_sync #(.W(PORT_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (sync_q)
    );

    // Peripheral drive vectors, one bit per pin
    always_comb begin
        per_en  = '0;
        per_oe  = '0;
        per_val = '0;
        per_en[PIN_SDA]  = twi_en;
        per_oe[PIN_SDA]  = twi_sda_oe;
        per_val[PIN_SDA] = twi_sda_o;
        per_en[PIN_SCL]  = twi_en;
        per_oe[PIN_SCL]  = twi_scl_oe;
        per_val[PIN_SCL] = twi_scl_o;
        per_en[PIN_TX]   = uart_tx_en;
        per_oe[PIN_TX]   = 1'b1;
        per_val[PIN_TX]  = uart_tx_o;
        per_en[PIN_RX]   = uart_rx_en;
        per_oe[PIN_RX]   = 1'b0;
        per_val[PIN_RX]  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            per_en[PIN_TMR+k]  = tmr_en[k];
            per_oe[PIN_TMR+k]  = tmr_oe[k];
            per_val[PIN_TMR+k] = tmr_o[k];
        end
    end

    generate
        for (genvar p = 0; p < PORT_W; p++) begin : g_pin
            pin_drive #(.OPEN_DRAIN(p < OD_PINS)) u_drv (
                .port_dir (dir_q[p]),
                .port_val (latch_q[p]),
                .per_en   (per_en[p]),
                .per_oe   (per_oe[p]),
                .per_val  (per_val[p]),
                .pad_oe   (pad_oe[p]),
                .pad_out  (pad_out[p])
            );
        end
    endgenerate

    assign twi_sda_i = sync_q[PIN_SDA];
    assign twi_scl_i = sync_q[PIN_SCL];
    assign uart_rx_i = sync_q[PIN_RX];
    assign tmr_i     = sync_q[PIN_TMR +: 4];
endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pad_in,
    input logic [7:0] pad_oe,
    input logic [7:0] pad_out,
    input logic       twi_en,
    input logic       twi_sda_oe,
    input logic       twi_sda_o,
    input logic       uart_rx_en,
    input logic [3:0] tmr_en,
    input logic [3:0] tmr_oe,
    input logic       twi_sda_i,
    input logic [3:0] tmr_i
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out[3:0] == 4'h0); // R5

    AST_SDA_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        twi_en |-> (pad_oe[0] == (twi_sda_oe & ~twi_sda_o))); // R7

    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        uart_rx_en |-> !pad_oe[3]); // R9

    AST_TMR_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en[0] |-> (pad_oe[4] == tmr_oe[0])); // R10

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (twi_sda_i == $past(pad_in[0], 2))); // R11

    AST_TMR_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (tmr_i == $past(pad_in[7:4], 2))); // R11
endmodule

bind gpio_shared_port gpio_shared_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .twi_en     (twi_en),
    .twi_sda_oe (twi_sda_oe),
    .twi_sda_o  (twi_sda_o),
    .uart_rx_en (uart_rx_en),
    .tmr_en     (tmr_en),
    .tmr_oe     (tmr_oe),
    .twi_sda_i  (twi_sda_i),
    .tmr_i      (tmr_i)
);

// File: tb/gpio_shared_port_tb.sv
`timescale 1ns/1ps
module gpio_shared_port_tb;
    localparam real HALF = 4.0;   // 125 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out;
    logic       twi_en = 0, twi_sda_oe = 0, twi_sda_o = 0, twi_scl_oe = 0, twi_scl_o = 0;
    logic       twi_sda_i, twi_scl_i;
    logic       uart_tx_en = 0, uart_tx_o = 0, uart_rx_en = 0, uart_rx_i;
    logic [3:0] tmr_en = '0, tmr_oe = '0, tmr_o = '0, tmr_i;

    int total = 0;
    int bad = 0;

    always #(HALF) clk = ~clk;

    gpio_shared_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .twi_en(twi_en),
        .twi_sda_oe(twi_sda_oe), .twi_sda_o(twi_sda_o), .twi_scl_oe(twi_scl_oe),
        .twi_scl_o(twi_scl_o), .twi_sda_i(twi_sda_i), .twi_scl_i(twi_scl_i),
        .uart_tx_en(uart_tx_en), .uart_tx_o(uart_tx_o), .uart_rx_en(uart_rx_en),
        .uart_rx_i(uart_rx_i), .tmr_en(tmr_en), .tmr_oe(tmr_oe), .tmr_o(tmr_o),
        .tmr_i(tmr_i)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] dir, input logic [7:0] lat);
        return (dir & 8'hF0) | (dir & ~lat & 8'h0F);
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] lat_pat [4];
        lat_pat[0] = 8'h00; lat_pat[1] = 8'hFF; lat_pat[2] = 8'hA5; lat_pat[3] = 8'h3C;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 oe after reset", pad_oe, 8'h00);
        bus_addr = 4'h5; #1;
        chk("R2 dir reads 0", bus_rdata, 8'h00);

        // R1 R5 R6 R4: sweep direction x latch, pads at a fixed pattern
        pad_in = 8'h96;
        repeat (2) @(negedge clk);
        for (int li = 0; li < 4; li++) begin
            wr(4'h1, lat_pat[li]);
            for (int d = 0; d < 256; d++) begin
                wr(4'h5, d[7:0]);
                chk("R5/R6 pad_oe", pad_oe, exp_oe(d[7:0], lat_pat[li]));
                chk("R5/R6 pad_out", pad_out, lat_pat[li] & d[7:0] & 8'hF0);
                bus_addr = 4'h1; #1;
                chk("R1/R4 readback", bus_rdata,
                    (lat_pat[li] & d[7:0]) | (8'h96 & ~d[7:0]));
            end
        end

        // R4 R11: synchronizer latency, all inputs
        wr(4'h5, 8'h00);
        bus_addr = 4'h1;
        for (int v = 0; v < 16; v++) begin
            logic [7:0] old_v;
            logic [7:0] new_v;
            old_v = pad_in;
            new_v = {v[3:0], ~v[3:0]};
            pad_in = new_v;
            @(negedge clk);
            chk("R4 one edge old", bus_rdata, old_v);
            @(negedge clk);
            chk("R4 two edges new", bus_rdata, new_v);
            chk("R11 periph inputs",
                {tmr_i, uart_rx_i, 1'b0, twi_scl_i, twi_sda_i},
                {new_v[7:4], new_v[3], 1'b0, new_v[1], new_v[0]});
        end
        // R11 with pins as outputs
        wr(4'h5, 8'hFF);
        pad_in = 8'h5A;
        repeat (2) @(negedge clk);
        chk("R11 periph inputs dir=out",
            {tmr_i, uart_rx_i, twi_scl_i, twi_sda_i}, {4'h5, 1'b1, 1'b1, 1'b0});

        // R3: latch survives reset
        wr(4'h1, 8'hC3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 oe after 2nd reset", pad_oe, 8'h00);
        wr(4'h5, 8'hFF);
        bus_addr = 4'h1; #1;
        chk("R3 latch kept", bus_rdata, 8'hC3);

        // R7: serial bus override, port set opposite
        for (int s = 0; s < 16; s++) begin
            logic [7:0] lat;
            lat = s[0] ? 8'h00 : 8'hFF;
            wr(4'h1, lat);
            wr(4'h5, s[1] ? 8'h00 : 8'hFF);
            @(negedge clk);
            twi_en = 1'b1;
            {twi_scl_oe, twi_scl_o, twi_sda_oe, twi_sda_o} = s[3:0];
            #1;
            chk("R7 pins 1..0 oe", {6'd0, pad_oe[1:0]},
                {6'd0, s[3] & ~s[2], s[1] & ~s[0]});
            chk("R5 od out", {4'd0, pad_out[3:0]}, 8'h00);
        end
        twi_en = 1'b0;

        // R8 R9: UART pins
        wr(4'h1, 8'h00);
        wr(4'h5, 8'h00);
        @(negedge clk);
        uart_tx_en = 1'b1; uart_tx_o = 1'b0; #1;
        chk("R8 tx low drives", {7'd0, pad_oe[2]}, 8'h01);
        uart_tx_o = 1'b1; #1;
        chk("R8 tx high releases", {7'd0, pad_oe[2]}, 8'h00);
        uart_tx_en = 1'b0;
        wr(4'h5, 8'hFF);
        uart_rx_en = 1'b1; #1;
        chk("R9 rx pin released", pad_oe, 8'hF7);
        uart_rx_en = 1'b0; #1;
        chk("R9 port restored", pad_oe, 8'hFF);

        // R10: timer channels, port set opposite
        wr(4'h1, 8'hF0);
        wr(4'h5, 8'h0F);
        @(negedge clk);
        tmr_en = 4'hF;
        for (int t = 0; t < 256; t++) begin
            {tmr_oe, tmr_o} = t[7:0]; #1;
            chk("R10 timer oe", {4'd0, pad_oe[7:4]}, {4'd0, t[7:4]});
            chk("R10 timer out", {4'd0, pad_out[7:4]}, {4'd0, t[7:4] & t[3:0]});
        end
        tmr_en = 4'h5; tmr_oe = 4'h0; #1;
        chk("R10 partial enable", {4'd0, pad_oe[7:4]}, 8'h00);
        tmr_en = 4'h0; #1;
        chk("R6 port after timers", pad_oe, 8'h0F);

        // R12: unmapped offsets
        wr(4'h1, 8'h81);
        wr(4'h5, 8'hFF);
        for (int a = 0; a < 16; a++) begin
            if (a != 1 && a != 5) begin
                wr(a[3:0], 8'h3C);
                bus_addr = a[3:0]; #1;
                chk("R12 unmapped reads 0", bus_rdata, 8'h00);
            end
        end
        bus_addr = 4'h1; #1;
        chk("R12 latch untouched", bus_rdata, 8'h81);
        bus_addr = 4'h5; #1;
        chk("R12 dir untouched", bus_rdata, 8'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule